// File: doc/BRIEF.md
# Programmable Clock Ratio Generator

This block derives four single-cycle enable strobes from one fast master clock. A peripheral enable fires once every D master cycles, with D taken from a 5-bit field of a 16-bit clock-speed word. A bus enable is carved out of the peripheral enable by an integer or fractional ratio. A timer enable divides the bus enable by 2 or 4. A counter strobe for a free-running count-compare timer divides the timer enable by 4, or by 2 when a revision-select input is high. No real clock is ever muxed; every output is a one-cycle qualifier in the master clock domain.

Firmware writes the clock-speed word and can read it back. The written word is held as pending and becomes active only at the next peripheral boundary, so a running enable period always completes. A mode input selects how the bus ratio field is decoded: a 4-bit fractional decode that includes divide-by-1.5 and divide-by-2.5, or a 3-bit integer decode in which two codes map to divides other than their value. A zero divisor stops the affected outputs, and a fault output reports it.

Top module: `clk_ratio_gen`

## Requirements
- R1: A write (cfgWe high) stores cfgWdata, and cfgRdata returns the stored word from the next cycle on; after reset the stored word is 16'h0000.
- R2: With a nonzero divisor D in bits 4:0 of the active word, periphEn pulses once every D cycles, the first pulse D cycles after the word takes effect.
- R3: With fracMode high, bits 11:8 give a code C: C=9 gives 2 bus pulses per 3 peripheral pulses, C=10 gives 2 per 5, any other nonzero C gives 1 per C; after k peripheral pulses the bus count is floor(k*num/den), and busEn only fires together with periphEn.
- R4: With fracMode low, bits 10:8 give a code C (bit 11 ignored): C=7 divides by 1, C=1 divides by 2, any other nonzero C divides by C.
- R5: timerEn fires on every 2nd busEn when bit 12 is 0 and on every 4th when bit 12 is 1.
- R6: countEn fires on every 4th timerEn when revSel is low and on every 2nd when revSel is high.
- R7: A zero divisor in bits 4:0 stops all four outputs and sets faultFlags[0].
- R8: A bus code of 0 stops busEn, timerEn and countEn while periphEn continues, and sets faultFlags[1].
- R9: A change of the stored word or of fracMode takes effect at the next periphEn pulse (or the next cycle if the peripheral output is stopped); the old period completes in full and all divider phases restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Clock-speed word write strobe |
| cfgWdata | input | 16 | Clock-speed word write data |
| fracMode | input | 1 | 1: fractional bus decode, 0: integer bus decode |
| revSel | input | 1 | 1: counter strobe divides timer by 2, 0: by 4 |
| cfgRdata | output | 16 | Stored clock-speed word |
| faultFlags | output | 2 | bit0: peripheral divisor zero, bit1: bus code zero (active word) |
| periphEn | output | 1 | Peripheral clock enable |
| busEn | output | 1 | Bus clock enable |
| timerEn | output | 1 | Timer clock enable |
| countEn | output | 1 | Count-compare timer strobe |

## Verification
A corrupted accumulator or sub-divider counter shows as a wrong pulse count on busEn, timerEn or countEn within one ratio period, so the bench sweeps every bus code in both decode modes, both timer divides and both revision settings, and compares exact pulse counts over a fixed window with floor arithmetic. A wrong apply point shows as a peripheral gap that is neither the old nor the new divisor, which a mid-period rewrite with recorded pulse times exposes within two peripheral periods. Nesting of the strobes and the fault-gated stops are checked every cycle by properties.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int CFG_W  = 16;
  localparam int PER_W  = 5;
  localparam int NUM_W  = 3;
  localparam int DEN_W  = 4;
  localparam int ACC_W  = DEN_W + 1;
  localparam int SUB_W  = 2;
  localparam int N_SUB  = 2;

  typedef struct packed {
    logic             load;
    logic [PER_W-1:0] perDiv;
    logic [NUM_W-1:0] busNum;
    logic [DEN_W-1:0] busDen;
    logic             tmrQuad;
  } dpCtl_t;

  // Map a clock-speed word and decode mode to divider settings.
  function automatic dpCtl_t decodeCfg(input logic [CFG_W-1:0] w, input logic frac);
    dpCtl_t d;
    logic [3:0] c4;
    logic [2:0] c3;
    c4 = w[11:8];
    c3 = w[10:8];
    d.load    = 1'b0;
    d.perDiv  = w[PER_W-1:0];
    d.tmrQuad = w[12];
    d.busNum  = NUM_W'(1);
    if (frac) begin
      case (c4)
        4'd9:    begin d.busNum = NUM_W'(6); d.busDen = DEN_W'(9);  end
        4'd10:   begin d.busNum = NUM_W'(4); d.busDen = DEN_W'(10); end
        default: d.busDen = c4;
      endcase
    end else begin
      case (c3)
        3'd7:    d.busDen = DEN_W'(1);
        3'd1:    d.busDen = DEN_W'(2);
        default: d.busDen = {1'b0, c3};
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             fracMode,
  input  logic             perTick,
  output logic [CFG_W-1:0] cfgRdata,
  output logic [1:0]       faultFlags,
  output dpCtl_t           dpCtl
);
  logic [CFG_W-1:0] pendReg, actReg;
  logic             actMode;
  logic             perStopped, differs, loadNow;
  dpCtl_t           dec;

  assign perStopped = (actReg[PER_W-1:0] == '0);
  assign differs    = ({fracMode, pendReg} != {actMode, actReg});
  assign loadNow    = differs && (perTick || perStopped);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= RST_CFG;
      actReg  <= RST_CFG;
      actMode <= 1'b0;
    end else begin
      if (cfgWe) pendReg <= cfgWdata;
      if (loadNow) begin
        actReg  <= pendReg;
        actMode <= fracMode;
      end
    end
  end

  always_comb begin
    dec        = decodeCfg(actReg, actMode);
    dpCtl      = dec;
    dpCtl.load = loadNow;
  end

  assign cfgRdata   = pendReg;
  assign faultFlags = {dec.busDen == '0, dec.perDiv == '0};
endmodule

// File: rtl/clk_ratio_subdiv.sv
module clk_ratio_subdiv
  import clk_ratio_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic tickIn,
  input  logic quad,
  output logic tickOut
);
  logic [SUB_W-1:0] cnt;
  logic [SUB_W-1:0] lim;

  assign lim     = quad ? SUB_W'(3) : SUB_W'(1);
  assign tickOut = tickIn && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rstN || clr)  cnt <= '0;
    else if (tickOut)  cnt <= '0;
    else if (tickIn)   cnt <= cnt + SUB_W'(1);
  end
endmodule

// File: rtl/clk_ratio_dp.sv
module clk_ratio_dp
  import clk_ratio_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t dpCtl,
  input  logic   revSel,
  output logic   periphEn,
  output logic   busEn,
  output logic   timerEn,
  output logic   countEn
);
  logic [PER_W-1:0] perCnt;
  logic [ACC_W-1:0] acc, accSum;
  logic             perHit, busHit;
  logic [N_SUB:0]   subTick;
  logic [N_SUB-1:0] subQuad;

  assign perHit = (dpCtl.perDiv != '0) && (perCnt == dpCtl.perDiv - PER_W'(1));
  assign accSum = acc + ACC_W'(dpCtl.busNum);
  assign busHit = perHit && (dpCtl.busDen != '0) && (accSum >= ACC_W'(dpCtl.busDen));

  always_ff @(posedge clk) begin
    if (!rstN || dpCtl.load || dpCtl.perDiv == '0) perCnt <= '0;
    else if (perHit)                                 perCnt <= '0;
    else                                             perCnt <= perCnt + PER_W'(1);
  end

  // Fractional accumulator: add numerator per peripheral tick, subtract denominator on overflow.
  always_ff @(posedge clk) begin
    if (!rstN || dpCtl.load) acc <= '0;
    else if (busHit)         acc <= accSum - ACC_W'(dpCtl.busDen);
    else if (perHit && dpCtl.busDen != '0) acc <= accSum;
  end

  assign subTick[0] = busHit;
  assign subQuad    = {!revSel, dpCtl.tmrQuad};

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    clk_ratio_subdiv u_sub (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (dpCtl.load),
      .tickIn (subTick[g]),
      .quad   (subQuad[g]),
      .tickOut(subTick[g+1])
    );
  end

  assign periphEn = perHit;
  assign busEn    = subTick[0];
  assign timerEn  = subTick[1];
  assign countEn  = subTick[2];
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clk_ratio_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             fracMode,
  input  logic             revSel,
  output logic [CFG_W-1:0] cfgRdata,
  output logic [1:0]       faultFlags,
  output logic             periphEn,
  output logic             busEn,
  output logic             timerEn,
  output logic             countEn
);
  dpCtl_t dpCtl;

  clk_ratio_ctrl #(.RST_CFG(RST_CFG)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgWdata  (cfgWdata),
    .fracMode  (fracMode),
    .perTick   (periphEn),
    .cfgRdata  (cfgRdata),
    .faultFlags(faultFlags),
    .dpCtl     (dpCtl)
  );

  clk_ratio_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .revSel  (revSel),
    .periphEn(periphEn),
    .busEn   (busEn),
    .timerEn (timerEn),
    .countEn (countEn)
  );
endmodule

// File: rtl/clk_ratio_checker.sv
module clk_ratio_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWe,
  input logic [15:0] cfgWdata,
  input logic [15:0] cfgRdata,
  input logic [1:0]  faultFlags,
  input logic        periphEn,
  input logic        busEn,
  input logic        timerEn,
  input logic        countEn
);
  p_readback_r1: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgRdata == $past(cfgWdata));

  p_bus_on_per_r3: assert property (@(posedge clk) disable iff (!rstN)
    busEn |-> periphEn);

  p_tmr_on_bus_r5: assert property (@(posedge clk) disable iff (!rstN)
    timerEn |-> busEn);

  p_cnt_on_tmr_r6: assert property (@(posedge clk) disable iff (!rstN)
    countEn |-> timerEn);

  p_per_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultFlags[0] |-> !periphEn && !busEn && !timerEn && !countEn);

  p_bus_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultFlags[1] |-> !busEn);

  // R9: the active word only changes at a peripheral boundary or while stopped.
  p_apply_point_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(faultFlags) |-> ($past(periphEn) || $past(faultFlags[0])));
endmodule

bind clk_ratio_gen clk_ratio_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWe     (cfgWe),
  .cfgWdata  (cfgWdata),
  .cfgRdata  (cfgRdata),
  .faultFlags(faultFlags),
  .periphEn  (periphEn),
  .busEn     (busEn),
  .timerEn   (timerEn),
  .countEn   (countEn)
);

// File: tb/clk_ratio_gen_tb_top.sv
`timescale 1ns/100ps
module clk_ratio_gen_tb_top;
  localparam int LWIN = 90;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic        fracMode = 1'b0;
  logic        revSel = 1'b0;
  logic [15:0] cfgRdata;
  logic [1:0]  faultFlags;
  logic        periphEn, busEn, timerEn, countEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clk_ratio_gen dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .fracMode(fracMode), .revSel(revSel), .cfgRdata(cfgRdata),
    .faultFlags(faultFlags), .periphEn(periphEn), .busEn(busEn),
    .timerEn(timerEn), .countEn(countEn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cfgWe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Write the word at a negedge; it is stored at the next edge and applied one edge later.
  task automatic writeCfg(input logic [15:0] w);
    cfgWe = 1'b1;
    cfgWdata = w;
    @(negedge clk);
    cfgWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic runCfg(input int div, input int code, input bit frac,
                        input bit quad, input bit rev);
    int num, den, nPer, nBus, nTmr, nCnt, ePer, eBus, eTmr, eCnt, cyc;
    logic [15:0] w;
    string tg;
    fracMode = frac;
    revSel = rev;
    doReset();
    if (frac) w = {3'b000, quad, 4'(code), 3'b000, 5'(div)};
    else      w = {3'b000, quad, 1'b1, 3'(code), 3'b000, 5'(div)};
    writeCfg(w);
    chk("R1 readback", int'(cfgRdata), int'(w));
    num = 1;
    if (frac) begin
      if (code == 9) begin num = 6; den = 9; end
      else if (code == 10) begin num = 4; den = 10; end
      else den = code;
    end else begin
      if (code == 7) den = 1;
      else if (code == 1) den = 2;
      else den = code;
    end
    ePer = (div == 0) ? 0 : LWIN;
    eBus = (den == 0) ? 0 : (ePer * num) / den;
    eTmr = eBus / (quad ? 4 : 2);
    eCnt = eTmr / (rev ? 2 : 4);
    nPer = 0; nBus = 0; nTmr = 0; nCnt = 0;
    cyc = (div == 0) ? 3 * LWIN : div * LWIN;
    // First sampled negedge is the first cycle with the new word active.
    for (int i = 0; i < cyc; i++) begin
      nPer += int'(periphEn);
      nBus += int'(busEn);
      nTmr += int'(timerEn);
      nCnt += int'(countEn);
      if (i < cyc - 1) @(negedge clk);
    end
    tg = $sformatf("div=%0d code=%0d frac=%0d quad=%0d rev=%0d", div, code, frac, quad, rev);
    chk({"R2/R7 periph ", tg}, nPer, ePer);
    chk({frac ? "R3 bus " : "R4 bus ", tg}, nBus, eBus);
    chk({"R5 timer ", tg}, nTmr, eTmr);
    chk({"R6 count ", tg}, nCnt, eCnt);
    chk({"R7/R8 fault ", tg}, int'(faultFlags),
        (den == 0 ? 2 : 0) + (div == 0 ? 1 : 0));
    @(negedge clk);
  endtask

  task automatic midChange();
    int hits[4];
    int nh, cyc;
    fracMode = 1'b0;
    revSel = 1'b0;
    doReset();
    writeCfg({3'b000, 1'b0, 1'b0, 3'd7, 3'b000, 5'd5});
    nh = 0;
    cyc = 0;
    while (nh < 4 && cyc < 40) begin
      if (periphEn) begin
        chk("R9 bus follows periph (div 1)", int'(busEn), 1);
        hits[nh] = cyc;
        nh++;
      end
      if (cyc == 7) begin
        cfgWe = 1'b1;
        cfgWdata = {3'b000, 1'b0, 1'b0, 3'd7, 3'b000, 5'd3};
      end else begin
        cfgWe = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    chk("R9 pulse count", nh, 4);
    chk("R9 old period", hits[0], 4);
    chk("R9 old period completes", hits[1], 9);
    chk("R9 new period", hits[2], 12);
    chk("R9 new period again", hits[3], 15);
  endtask

  initial begin
    doReset();
    @(negedge clk);
    chk("R1 reset readback", int'(cfgRdata), 0);
    chk("R7 reset fault", int'(faultFlags), 3);
    chk("R7 reset periph", int'(periphEn), 0);
    chk("R7 reset count", int'(countEn), 0);

    runCfg(0, 5, 1'b1, 1'b0, 1'b0);
    runCfg(0, 3, 1'b0, 1'b1, 1'b1);
    for (int d = 1; d <= 3; d += 2)
      for (int cmb = 0; cmb < 4; cmb++) begin
        for (int c = 0; c < 16; c++) runCfg(d, c, 1'b1, cmb[0], cmb[1]);
        for (int c = 0; c < 8; c++)  runCfg(d, c, 1'b0, cmb[0], cmb[1]);
      end
    midChange();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule